// File: doc/BRIEF.md
# Serial Boot Loader Sequencer

This block runs the byte-level handshake of a serial boot session once the serial link's bit rate has been calibrated. It sits between a UART receive/transmit byte interface, the erase controls of the on-chip non-volatile memory, and a RAM write port. It waits for a start code from the host. It then makes sure the non-volatile memory is blank, erasing it if needed, and tells the host whether that worked.

After a good erase it takes a 16-bit program length and echoes both length bytes. It then takes that many program bytes, echoing each one and writing it into RAM at consecutive addresses from a parameterized base. When the last byte has been echoed, it pulses a start-execution strobe so the CPU can branch into the loaded code. A failed erase ends the session in a halted state that only a reset clears. Interrupts are held masked while erasing or loading is in progress.

Top module: `boot_loader_seq`

## Requirements
- R1: After reset the block waits for the start code: rx_ready is 1, and tx_valid, erase_req, irq_mask, ram_we and start_exec are all 0.
- R2: While waiting for the start code, any byte received with rx_err set, and any byte whose value is not 0x55, is consumed and ignored: no byte is sent, no erase is requested, and the block keeps waiting.
- R3: When 0x55 is received with no error and mem_blank is 1, the block transmits 0xAA without ever asserting erase_req.
- R4: When 0x55 is received with no error and mem_blank is 0, erase_req rises and stays high until erase_done or erase_fail. On erase_done the block transmits 0xAA.
- R5: On erase_fail (which wins over erase_done) the block transmits 0xFF and halts. From then on rx_ready stays 0, no further byte is sent, and start_exec never pulses until reset.
- R6: The program length N arrives as two error-free bytes, the high byte first and then the low byte. Each is echoed unchanged. Bytes with rx_err set are consumed and ignored.
- R7: Each of the N program bytes is echoed unchanged, in the order received. For byte i (counting from 0) there is exactly one one-cycle ram_we pulse with ram_wdata equal to that byte and ram_addr = (RAM_BASE + i) mod 2^ADDR_W.
- R8: start_exec pulses for exactly one cycle, once per session, after the transmitter has accepted the last echo. With N = 0, that last echo is the echo of the low length byte.
- R9: irq_mask is 1 while erase_req is high and while program bytes remain to be loaded (from the cycle after the low length byte is accepted with N > 0 until the cycle after the last program byte). It is 0 at every other time, including after start_exec.
- R10: A transmit byte is offered with tx_valid and held with stable tx_data until a cycle in which tx_ready is 1. While a byte is pending, rx_ready is 0, so no new byte is accepted before its echo has been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (also driven by watchdog overflow) |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte value |
| rx_err | input | 1 | Received byte had a framing error |
| rx_ready | output | 1 | Block takes the received byte this cycle |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Offered byte value |
| erase_req | output | 1 | Full erase request, held until done or fail |
| erase_done | input | 1 | Erase finished successfully |
| erase_fail | input | 1 | Erase failed |
| mem_blank | input | 1 | Non-volatile memory holds no written data |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| irq_mask | output | 1 | Interrupts masked while erasing or loading |
| start_exec | output | 1 | One-cycle strobe to branch to the loaded program |

## Verification
The bench builds the block with ADDR_W = 6 and RAM_BASE = 0x30, so a 64-word address space wraps after only 16 program bytes. That makes the modulo address rule reachable with short transfers. It sweeps every length from 0 to 20, alternating blank and erased memory, and adds a 300-byte run that uses a nonzero high length byte and wraps the address space several times. One further session forces an erase failure to reach the halted state. Transmitter stalls of varying length are inserted on every echo.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam logic [7:0] CODE_START = 8'h55;
    localparam logic [7:0] CODE_OK    = 8'hAA;
    localparam logic [7:0] CODE_FAIL  = 8'hFF;
    localparam int         LEN_W      = 16;

    typedef enum logic [3:0] {
        ST_WAIT_START,
        ST_CHECK,
        ST_ERASE,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_LOAD,
        ST_GO,
        ST_DONE,
        ST_HALT
    } boot_state_e;

endpackage

// File: rtl/boot_tx_slot.sv
module boot_tx_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data
);

    typedef struct packed {
        logic       pend;
        logic [7:0] data;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.pend = 1'b1;
            s_d.data = push_byte;
        end else if (s_q.pend && tx_ready) begin
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_valid = s_q.pend;
    assign tx_data  = s_q.data;

    // R10: a new byte never overwrites one still pending
    assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !s_q.pend);

    // R10: an offered byte stays put until taken
    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/boot_xfer_cnt.sv
module boot_xfer_cnt #(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  len,
    input  logic              step,
    output logic [ADDR_W-1:0] offset,
    output logic              last
);

    typedef struct packed {
        logic [LEN_W-1:0]  remaining;
        logic [ADDR_W-1:0] offset;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.remaining = len;
            c_d.offset    = '0;
        end else if (step) begin
            c_d.remaining = c_q.remaining - 1'b1;
            c_d.offset    = c_q.offset + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign offset = c_q.offset;
    assign last   = (c_q.remaining == {{(LEN_W-1){1'b0}}, 1'b1});

    // R7: no byte is loaded beyond the announced length
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (c_q.remaining != '0));

endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
    import boot_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RAM_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_err,
    output logic              rx_ready,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              erase_req,
    input  logic              erase_done,
    input  logic              erase_fail,
    input  logic              mem_blank,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              irq_mask,
    output logic              start_exec
);

    typedef struct packed {
        boot_state_e       state;
        logic [7:0]        len_hi;
        logic              ram_we;
        logic [ADDR_W-1:0] ram_addr;
        logic [7:0]        ram_wdata;
        logic              start;
    } seq_t;

    seq_t r_d, r_q;

    logic              push;
    logic [7:0]        push_byte;
    logic              cnt_load;
    logic              cnt_step;
    logic [ADDR_W-1:0] cnt_offset;
    logic              cnt_last;
    logic              good;
    logic [LEN_W-1:0]  len_full;

    assign rx_ready = !tx_valid &&
                      ((r_q.state == ST_WAIT_START) || (r_q.state == ST_LEN_HI) ||
                       (r_q.state == ST_LEN_LO)     || (r_q.state == ST_LOAD));
    assign good     = rx_valid && rx_ready && !rx_err;
    assign len_full = {r_q.len_hi, rx_data};

    always_comb begin
        r_d        = r_q;
        r_d.ram_we = 1'b0;
        r_d.start  = 1'b0;
        push       = 1'b0;
        push_byte  = rx_data;
        cnt_load   = 1'b0;
        cnt_step   = 1'b0;
        case (r_q.state)
            ST_WAIT_START: begin
                if (good && (rx_data == CODE_START)) r_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (mem_blank) begin
                    push      = 1'b1;
                    push_byte = CODE_OK;
                    r_d.state = ST_LEN_HI;
                end else begin
                    r_d.state = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (erase_fail) begin
                    push      = 1'b1;
                    push_byte = CODE_FAIL;
                    r_d.state = ST_HALT;
                end else if (erase_done) begin
                    push      = 1'b1;
                    push_byte = CODE_OK;
                    r_d.state = ST_LEN_HI;
                end
            end
            ST_LEN_HI: begin
                if (good) begin
                    r_d.len_hi = rx_data;
                    push       = 1'b1;
                    r_d.state  = ST_LEN_LO;
                end
            end
            ST_LEN_LO: begin
                if (good) begin
                    push      = 1'b1;
                    cnt_load  = 1'b1;
                    r_d.state = (len_full == '0) ? ST_GO : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (good) begin
                    push          = 1'b1;
                    cnt_step      = 1'b1;
                    r_d.ram_we    = 1'b1;
                    r_d.ram_addr  = RAM_BASE + cnt_offset;
                    r_d.ram_wdata = rx_data;
                    if (cnt_last) r_d.state = ST_GO;
                end
            end
            ST_GO: begin
                if (!tx_valid) begin
                    r_d.start = 1'b1;
                    r_d.state = ST_DONE;
                end
            end
            default: r_d.state = r_q.state;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_WAIT_START;
        end else begin
            r_q <= r_d;
        end
    end

    boot_tx_slot u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (push_byte),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    boot_xfer_cnt #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .len    (len_full),
        .step   (cnt_step),
        .offset (cnt_offset),
        .last   (cnt_last)
    );

    assign erase_req  = (r_q.state == ST_ERASE);
    assign irq_mask   = (r_q.state == ST_ERASE) || (r_q.state == ST_LOAD);
    assign ram_we     = r_q.ram_we;
    assign ram_addr   = r_q.ram_addr;
    assign ram_wdata  = r_q.ram_wdata;
    assign start_exec = r_q.start;

    // R4: the erase request is held until the flash side answers
    assert_erase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done && !erase_fail) |=> erase_req);

    // R5: a halted session stays silent
    assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HALT) |=> (!rx_ready && !start_exec && !erase_req && (r_q.state == ST_HALT)));

    // R8: the start strobe lasts one cycle
    assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_exec |=> !start_exec);

    // R8: start only once the transmitter has nothing left
    assert_start_after_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_exec) |-> $past(!tx_valid));

    // R9: every RAM write follows a masked cycle
    assert_write_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(irq_mask));

endmodule

// File: tb/boot_loader_seq_tb.sv
module boot_loader_seq_tb;

    localparam int              AW   = 6;
    localparam logic [AW-1:0]   BASE = 6'h30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_err = 1'b0;
    logic          rx_ready;
    logic          tx_ready = 1'b0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          erase_req;
    logic          erase_done = 1'b0;
    logic          erase_fail = 1'b0;
    logic          mem_blank = 1'b1;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic          irq_mask;
    logic          start_exec;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_cnt   = 0;
    int st_cnt   = 0;
    int erase_seen = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    boot_loader_seq #(.ADDR_W(AW), .RAM_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .rx_ready(rx_ready), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .erase_req(erase_req),
        .erase_done(erase_done), .erase_fail(erase_fail), .mem_blank(mem_blank),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .irq_mask(irq_mask), .start_exec(start_exec)
    );

    function automatic logic [7:0] pbyte(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // RAM write and start strobe monitor
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            check(ram_addr == AW'((int'(BASE) + wr_cnt) % 64), "R7 addr", int'(ram_addr),
                  (int'(BASE) + wr_cnt) % 64);
            check(ram_wdata == pbyte(wr_cnt), "R7 data", int'(ram_wdata), int'(pbyte(wr_cnt)));
            wr_cnt++;
        end
        if (rst_n && start_exec) st_cnt++;
        if (rst_n && erase_req) erase_seen++;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0; tx_ready = 1'b0; erase_done = 1'b0; erase_fail = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr_cnt = 0; st_cnt = 0; erase_seen = 0;
        @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic err);
        int t = 0;
        while (!rx_ready && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(rx_ready, "R10 rx_ready timeout", 0, 1);
        rx_valid = 1'b1; rx_data = b; rx_err = err;
        @(negedge clk);
        rx_valid = 1'b0; rx_err = 1'b0;
    endtask

    task automatic expect_tx(input logic [7:0] b, input int hold, input string req);
        int t = 0;
        while (!tx_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(tx_valid && tx_data == b, req, int'(tx_data), int'(b));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(tx_valid && tx_data == b && !rx_ready, "R10 hold", int'(tx_data), int'(b));
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic run_session(input int n, input bit blank);
        do_reset();
        check(rx_ready && !tx_valid && !erase_req && !irq_mask && !ram_we && !start_exec,
              "R1 reset", {rx_ready, tx_valid, erase_req, irq_mask, ram_we, start_exec}, 6'b100000);
        mem_blank = blank;
        send_rx(8'h13, 1'b0);
        send_rx(8'h55, 1'b1);
        send_rx(8'hAA, 1'b0);
        repeat (4) @(negedge clk);
        check(!tx_valid && !erase_req && rx_ready, "R2 ignored",
              {tx_valid, erase_req, rx_ready}, 3'b001);
        send_rx(8'h55, 1'b0);
        if (!blank) begin
            int t = 0;
            while (!erase_req && t < 100) begin
                @(negedge clk);
                t++;
            end
            repeat (3) @(negedge clk);
            check(erase_req && irq_mask && !tx_valid, "R4 erase held", {erase_req, irq_mask}, 2'b11);
            erase_done = 1'b1;
            @(negedge clk);
            erase_done = 1'b0;
            check(!erase_req, "R4 erase released", int'(erase_req), 0);
        end
        expect_tx(8'hAA, n % 3, blank ? "R3 ok code" : "R4 ok code");
        if (blank) check(erase_seen == 0, "R3 no erase", erase_seen, 0);
        check(!irq_mask, "R9 mask before length", int'(irq_mask), 0);
        send_rx(8'hEE, 1'b1);
        send_rx(8'(n >> 8), 1'b0);
        expect_tx(8'(n >> 8), 1, "R6 echo hi");
        send_rx(8'hEE, 1'b1);
        send_rx(8'(n & 255), 1'b0);
        expect_tx(8'(n & 255), 2, "R6 echo lo");
        for (int i = 0; i < n; i++) begin
            check(irq_mask, "R9 mask during load", int'(irq_mask), 1);
            send_rx(pbyte(i), 1'b0);
            expect_tx(pbyte(i), i % 3, "R7 echo");
        end
        repeat (4) @(negedge clk);
        check(st_cnt == 1, "R8 start count", st_cnt, 1);
        check(wr_cnt == n, "R7 write count", wr_cnt, n);
        check(!irq_mask && !rx_ready, "R9 mask after start", {irq_mask, rx_ready}, 0);
    endtask

    initial begin
        for (int n = 0; n <= 20; n++) run_session(n, n[0]);
        run_session(300, 1'b0);

        // R5: erase failure halts the session
        do_reset();
        mem_blank = 1'b0;
        send_rx(8'h55, 1'b0);
        repeat (2) @(negedge clk);
        erase_fail = 1'b1; erase_done = 1'b1;
        @(negedge clk);
        erase_fail = 1'b0; erase_done = 1'b0;
        expect_tx(8'hFF, 2, "R5 fail code");
        rx_valid = 1'b1; rx_data = 8'h00;
        repeat (10) @(negedge clk);
        rx_valid = 1'b0;
        check(!rx_ready && !tx_valid && !erase_req && st_cnt == 0, "R5 halted",
              {rx_ready, tx_valid, erase_req}, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule